// File: doc/BRIEF.md
# DRAM Mode Register File

This block models, on the device side, how a DRAM takes mode-register-set commands and turns the stored words into live controls. A strobe arrives with a two-bit bank select and a 19-bit address value. Bank 1 is the extended control word, and its fields drive the outputs. A bank 0 write can request a DLL reset, and that request is returned as a single-cycle pulse instead of being stored. Writes to banks 2 and 3 are accepted and have no visible effect.

The block also tracks self refresh. On entry the DLL shuts down. On exit it comes back, with a reset pulse, but only if it was enabled before entry. Additive latency is produced in clock cycles, relative to a CAS latency value supplied from outside. The data-mask function is reported as unavailable while the termination strobe is enabled. Any reserved bit or reserved encoding in the control word sets a sticky error flag, while the word is still stored as written.

Top module: `mode_reg_bank`

## Requirements
- R1: While reset is asserted and after its release, with no writes: dllOn=1, driveCode=00, termCode=000, addLat=0, wrLevelOn=0, tdqsOn=0, outOff=0, maskActive=1, dllResetPulse=0, cfgError=0.
- R2: A strobe with bank 01 stores the address word. From the next cycle: dllOn = NOT bit 0 (outside self refresh), driveCode = {bit 5, bit 1}, termCode = {bit 9, bit 6, bit 2}, wrLevelOn = bit 7, tdqsOn = bit 11, outOff = bit 12.
- R3: The stored bits [4:3] select addLat as follows: 00 gives 0, 01 gives casLat-1, 10 gives casLat-2, and 11 gives 0. addLat follows a change of casLat in the same cycle.
- R4: A strobe with bank 00 and address bit 8 set raises dllResetPulse for exactly the next cycle. The bit is not retained, so a later bank 00 write with bit 8 clear gives no pulse. Bank 00 writes leave the control outputs unchanged.
- R5: Strobes with bank 10 or 11 change no output, whatever the address value.
- R6: maskActive is 0 whenever tdqsOn is 1, and 1 otherwise.
- R7: If the DLL is enabled (stored bit 0 = 0), srEnter drives dllOn to 0 from the next cycle until srExit. In the cycle after srExit, dllOn returns to 1 and dllResetPulse is 1 for one cycle. An srExit with no self refresh in progress is ignored.
- R8: If the DLL is disabled (stored bit 0 = 1) before self refresh, dllOn stays 0 after srExit, and no reset pulse is produced.
- R9: A bank 01 word with any of bits 18, 15, 14, 13, 10 or 8 set, with bits [4:3] = 11, or with bit 5 set (drive codes 10/11) sets cfgError from the next cycle. The flag stays set through later valid writes until reset, and the fields still show the stored word.
- R10: Termination code validity sets cfgError as follows. With bit 7 = 0, codes 101, 110 and 111 are errors. With bit 7 = 1 and bit 12 = 0, codes 100 to 111 are errors. With bit 7 = 1 and bit 12 = 1, only 110 and 111 are errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears all state |
| mrsValid | input | 1 | Mode-register-set strobe |
| mrsBank | input | 2 | Target register select |
| mrsAddr | input | 19 | Value written with the strobe |
| srEnter | input | 1 | Self-refresh entry strobe |
| srExit | input | 1 | Self-refresh exit strobe |
| casLat | input | 5 | CAS latency in cycles |
| dllOn | output | 1 | DLL currently running |
| driveCode | output | 2 | Output drive strength code |
| termCode | output | 3 | Nominal termination code |
| addLat | output | 5 | Additive latency in cycles |
| wrLevelOn | output | 1 | Write leveling enabled |
| tdqsOn | output | 1 | Termination strobe enabled |
| outOff | output | 1 | Data and strobe outputs tri-stated |
| maskActive | output | 1 | Data mask function available |
| dllResetPulse | output | 1 | One-cycle DLL reset request |
| cfgError | output | 1 | Sticky reserved-encoding flag |

## Verification
Every decoded field, the error flag, the DLL state and the reset pulse come from one register stage. Each is therefore due in the cycle right after the clock edge that captures a write or a self-refresh strobe, and the pulse falls again one edge later. Additive latency is the one exception: it tracks casLat with no register in between.

The bench drives stimulus on the falling edge and lets exactly one rising edge pass. It then samples at the next falling edge, and samples again one cycle later wherever a result must not persist. Each validity case starts from a fresh reset, so the sticky flag of one case cannot hide the result of the next.

// File: rtl/mode_reg_pkg.sv
package mode_reg_pkg;

  localparam int MR_W   = 19;
  localparam int BANK_W = 2;
  localparam int LAT_W  = 5;

  localparam logic [BANK_W-1:0] BANK_CLK_CFG = BANK_W'(0);
  localparam logic [BANK_W-1:0] BANK_CTL_CFG = BANK_W'(1);

  localparam int B_DLL_OFF  = 0;
  localparam int B_DRV_LO   = 1;
  localparam int B_TRM_LO   = 2;
  localparam int B_AL_LO    = 3;
  localparam int B_AL_HI    = 4;
  localparam int B_DRV_HI   = 5;
  localparam int B_TRM_MID  = 6;
  localparam int B_WLEV     = 7;
  localparam int B_DLL_RST  = 8;
  localparam int B_TRM_HI   = 9;
  localparam int B_TDQS     = 11;
  localparam int B_QOFF     = 12;

  localparam logic [MR_W-1:0] RESV_MASK = MR_W'(19'h4E500);

  typedef struct packed {
    logic loadCfg;
    logic srHold;
  } mrCtlT;

  typedef enum logic [1:0] {
    AL_ZERO = 2'b00,
    AL_CLM1 = 2'b01,
    AL_CLM2 = 2'b10,
    AL_RSVD = 2'b11
  } alSelT;

  function automatic logic termLegal(input logic [2:0] code,
                                     input logic wl,
                                     input logic qoff);
    logic ok;
    if (!wl)        ok = (code <= 3'd4);
    else if (!qoff) ok = (code <= 3'd3);
    else            ok = (code <= 3'd5);
    return ok;
  endfunction

endpackage

// File: rtl/mode_reg_ctrl.sv
module mode_reg_ctrl
  import mode_reg_pkg::*;
#(
  parameter int BANK_W_P = BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsValid,
  input  logic [BANK_W_P-1:0] mrsBank,
  input  logic              rstReq,
  input  logic              srEnter,
  input  logic              srExit,
  input  logic              mr1DllOff,
  output mrCtlT             ctl,
  output logic              dllResetPulse
);

  logic srState;
  logic pulseQ;
  logic clkCfgRst;
  logic srLeave;

  assign clkCfgRst = mrsValid && (mrsBank == BANK_W_P'(BANK_CLK_CFG)) && rstReq;
  assign srLeave   = srExit && srState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srState <= 1'b0;
      pulseQ  <= 1'b0;
    end else begin
      if (srLeave)                srState <= 1'b0;
      else if (srEnter)           srState <= 1'b1;
      pulseQ <= clkCfgRst || (srLeave && !mr1DllOff);
    end
  end

  always_comb begin
    ctl.loadCfg = mrsValid && (mrsBank == BANK_W_P'(BANK_CTL_CFG));
    ctl.srHold  = srState;
  end

  assign dllResetPulse = pulseQ;

endmodule

// File: rtl/mode_reg_dp.sv
module mode_reg_dp
  import mode_reg_pkg::*;
#(
  parameter int ADDR_W_P = MR_W,
  parameter int LAT_W_P  = LAT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  mrCtlT               ctl,
  input  logic [ADDR_W_P-1:0] mrsAddr,
  input  logic [LAT_W_P-1:0]  casLat,
  output logic                mr1DllOff,
  output logic                dllOn,
  output logic [1:0]          driveCode,
  output logic [2:0]          termCode,
  output logic [LAT_W_P-1:0]  addLat,
  output logic                wrLevelOn,
  output logic                tdqsOn,
  output logic                outOff,
  output logic                maskActive,
  output logic                cfgError
);

  logic [ADDR_W_P-1:0] cfgWord;
  logic                errSticky;
  logic                wordBad;
  alSelT               alSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord   <= '0;
      errSticky <= 1'b0;
    end else begin
      if (ctl.loadCfg) cfgWord <= mrsAddr;
      errSticky <= errSticky || wordBad;
    end
  end

  assign alSel     = alSelT'(cfgWord[B_AL_HI:B_AL_LO]);
  assign driveCode = {cfgWord[B_DRV_HI], cfgWord[B_DRV_LO]};
  assign termCode  = {cfgWord[B_TRM_HI], cfgWord[B_TRM_MID], cfgWord[B_TRM_LO]};
  assign wrLevelOn = cfgWord[B_WLEV];
  assign tdqsOn    = cfgWord[B_TDQS];
  assign outOff    = cfgWord[B_QOFF];
  assign mr1DllOff = cfgWord[B_DLL_OFF];
  assign dllOn     = !cfgWord[B_DLL_OFF] && !ctl.srHold;

  always_comb begin
    maskActive = 1'b1;
    if (tdqsOn) maskActive = 1'b0;
  end

  always_comb begin
    unique case (alSel)
      AL_CLM1: addLat = casLat - LAT_W_P'(1);
      AL_CLM2: addLat = casLat - LAT_W_P'(2);
      AL_ZERO: addLat = '0;
      AL_RSVD: addLat = '0;
      default: addLat = '0;
    endcase
  end

  always_comb begin
    wordBad = 1'b0;
    if (|(cfgWord & ADDR_W_P'(RESV_MASK)))        wordBad = 1'b1;
    if (alSel == AL_RSVD)                         wordBad = 1'b1;
    if (cfgWord[B_DRV_HI])                        wordBad = 1'b1;
    if (!termLegal(termCode, wrLevelOn, outOff))  wordBad = 1'b1;
  end

  assign cfgError = errSticky || wordBad;

endmodule

// File: rtl/mode_reg_bank.sv
module mode_reg_bank
  import mode_reg_pkg::*;
#(
  parameter int ADDR_W = MR_W,
  parameter int BANK_SEL_W = BANK_W,
  parameter int CL_W = LAT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mrsValid,
  input  logic [BANK_SEL_W-1:0] mrsBank,
  input  logic [ADDR_W-1:0]     mrsAddr,
  input  logic                  srEnter,
  input  logic                  srExit,
  input  logic [CL_W-1:0]       casLat,
  output logic                  dllOn,
  output logic [1:0]            driveCode,
  output logic [2:0]            termCode,
  output logic [CL_W-1:0]       addLat,
  output logic                  wrLevelOn,
  output logic                  tdqsOn,
  output logic                  outOff,
  output logic                  maskActive,
  output logic                  dllResetPulse,
  output logic                  cfgError
);

  mrCtlT ctl;
  logic  mr1DllOff;

  mode_reg_ctrl #(.BANK_W_P(BANK_SEL_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .mrsValid     (mrsValid),
    .mrsBank      (mrsBank),
    .rstReq       (mrsAddr[B_DLL_RST]),
    .srEnter      (srEnter),
    .srExit       (srExit),
    .mr1DllOff    (mr1DllOff),
    .ctl          (ctl),
    .dllResetPulse(dllResetPulse)
  );

  mode_reg_dp #(.ADDR_W_P(ADDR_W), .LAT_W_P(CL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .mrsAddr   (mrsAddr),
    .casLat    (casLat),
    .mr1DllOff (mr1DllOff),
    .dllOn     (dllOn),
    .driveCode (driveCode),
    .termCode  (termCode),
    .addLat    (addLat),
    .wrLevelOn (wrLevelOn),
    .tdqsOn    (tdqsOn),
    .outOff    (outOff),
    .maskActive(maskActive),
    .cfgError  (cfgError)
  );

endmodule

// File: rtl/mode_reg_bank_chk.sv
module mode_reg_bank_chk #(
  parameter int ADDR_W = 19,
  parameter int BANK_SEL_W = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  mrsValid,
  input logic [BANK_SEL_W-1:0] mrsBank,
  input logic [ADDR_W-1:0]     mrsAddr,
  input logic                  srEnter,
  input logic                  srExit,
  input logic                  dllOn,
  input logic [1:0]            driveCode,
  input logic [2:0]            termCode,
  input logic                  wrLevelOn,
  input logic                  tdqsOn,
  input logic                  outOff,
  input logic                  dllResetPulse,
  input logic                  cfgError
);

  p_load_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mrsValid && mrsBank == BANK_SEL_W'(1)) |=>
      (outOff == $past(mrsAddr[12]) && tdqsOn == $past(mrsAddr[11]) &&
       wrLevelOn == $past(mrsAddr[7])));

  p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    dllResetPulse |->
      $past((mrsValid && mrsBank == BANK_SEL_W'(0) && mrsAddr[8]) || srExit));

  p_other_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mrsValid && mrsBank >= BANK_SEL_W'(2)) |=>
      $stable({driveCode, termCode, wrLevelOn, tdqsOn, outOff}));

  p_sr_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (srEnter && !srExit) |=> !dllOn);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

endmodule

bind mode_reg_bank mode_reg_bank_chk #(.ADDR_W(ADDR_W), .BANK_SEL_W(BANK_SEL_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .mrsValid     (mrsValid),
  .mrsBank      (mrsBank),
  .mrsAddr      (mrsAddr),
  .srEnter      (srEnter),
  .srExit       (srExit),
  .dllOn        (dllOn),
  .driveCode    (driveCode),
  .termCode     (termCode),
  .wrLevelOn    (wrLevelOn),
  .tdqsOn       (tdqsOn),
  .outOff       (outOff),
  .dllResetPulse(dllResetPulse),
  .cfgError     (cfgError)
);

// File: tb/mode_reg_bank_test.sv
`timescale 1ns/1ps
module mode_reg_bank_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        mrsValid;
  logic [1:0]  mrsBank;
  logic [18:0] mrsAddr;
  logic        srEnter;
  logic        srExit;
  logic [4:0]  casLat;
  logic        dllOn;
  logic [1:0]  driveCode;
  logic [2:0]  termCode;
  logic [4:0]  addLat;
  logic        wrLevelOn;
  logic        tdqsOn;
  logic        outOff;
  logic        maskActive;
  logic        dllResetPulse;
  logic        cfgError;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mode_reg_bank uut (
    .clk(clk), .rstN(rstN), .mrsValid(mrsValid), .mrsBank(mrsBank),
    .mrsAddr(mrsAddr), .srEnter(srEnter), .srExit(srExit), .casLat(casLat),
    .dllOn(dllOn), .driveCode(driveCode), .termCode(termCode), .addLat(addLat),
    .wrLevelOn(wrLevelOn), .tdqsOn(tdqsOn), .outOff(outOff),
    .maskActive(maskActive), .dllResetPulse(dllResetPulse), .cfgError(cfgError)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; mrsValid = 1'b0; mrsBank = '0; mrsAddr = '0;
    srEnter = 1'b0; srExit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // drive on a falling edge, one rising edge captures, sample at the next falling edge
  task automatic doWrite(input logic [1:0] bank, input logic [18:0] val);
    mrsValid = 1'b1; mrsBank = bank; mrsAddr = val;
    @(negedge clk);
    mrsValid = 1'b0; mrsAddr = '0; mrsBank = '0;
  endtask

  task automatic srPulse(input bit enter);
    if (enter) srEnter = 1'b1; else srExit = 1'b1;
    @(negedge clk);
    srEnter = 1'b0; srExit = 1'b0;
  endtask

  function automatic logic [18:0] termBits(input logic [2:0] c);
    return (19'(c[2]) << 9) | (19'(c[1]) << 6) | (19'(c[0]) << 2);
  endfunction

  task automatic tReset();
    rstN = 1'b0; mrsValid = 1'b0; mrsBank = '0; mrsAddr = '0;
    srEnter = 1'b0; srExit = 1'b0; casLat = 5'd11;
    @(negedge clk);
    chk("R1 dllOn in reset", dllOn, 1);
    chk("R1 cfgError in reset", cfgError, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 dllOn", dllOn, 1);
    chk("R1 driveCode", driveCode, 0);
    chk("R1 termCode", termCode, 0);
    chk("R1 addLat", addLat, 0);
    chk("R1 wrLevelOn", wrLevelOn, 0);
    chk("R1 tdqsOn", tdqsOn, 0);
    chk("R1 outOff", outOff, 0);
    chk("R1 maskActive", maskActive, 1);
    chk("R1 dllResetPulse", dllResetPulse, 0);
    chk("R1 cfgError", cfgError, 0);
  endtask

  task automatic tFields();
    doReset();
    // dll off, drive 01, term 011, tdqs on
    doWrite(2'b01, 19'd2119);
    chk("R2 dllOn", dllOn, 0);
    chk("R2 driveCode", driveCode, 2'b01);
    chk("R2 termCode", termCode, 3'b011);
    chk("R2 tdqsOn", tdqsOn, 1);
    chk("R2 wrLevelOn", wrLevelOn, 0);
    chk("R6 maskActive with tdqs", maskActive, 0);
    chk("R2 cfgError", cfgError, 0);
    // write leveling, outputs off, term 100
    doWrite(2'b01, 19'd4736);
    chk("R2 dllOn second", dllOn, 1);
    chk("R2 wrLevelOn second", wrLevelOn, 1);
    chk("R2 outOff second", outOff, 1);
    chk("R2 termCode second", termCode, 3'b100);
    chk("R2 tdqsOn second", tdqsOn, 0);
    chk("R6 maskActive without tdqs", maskActive, 1);
    chk("R10 term 100 legal in leveling with outputs off", cfgError, 0);
  endtask

  task automatic tAddLat();
    doReset();
    casLat = 5'd11;
    doWrite(2'b01, 19'd8);
    chk("R3 CL-1", addLat, 10);
    casLat = 5'd9;
    #1;
    chk("R3 follows casLat", addLat, 8);
    doWrite(2'b01, 19'd16);
    chk("R3 CL-2", addLat, 7);
    doWrite(2'b01, 19'd0);
    chk("R3 zero", addLat, 0);
    chk("R3 no error", cfgError, 0);
  endtask

  task automatic tDllReset();
    doReset();
    doWrite(2'b00, 19'd256);
    chk("R4 pulse high", dllResetPulse, 1);
    chk("R4 mr0 leaves dllOn", dllOn, 1);
    chk("R4 mr0 leaves termCode", termCode, 0);
    @(negedge clk);
    chk("R4 pulse single cycle", dllResetPulse, 0);
    doWrite(2'b00, 19'd0);
    chk("R4 bit not retained", dllResetPulse, 0);
  endtask

  task automatic tOtherBanks();
    doReset();
    doWrite(2'b01, 19'd2119);
    doWrite(2'b10, 19'h7FFFF);
    chk("R5 bank2 termCode", termCode, 3'b011);
    chk("R5 bank2 pulse", dllResetPulse, 0);
    doWrite(2'b11, 19'h7FFFF);
    chk("R5 bank3 driveCode", driveCode, 2'b01);
    chk("R5 bank3 tdqsOn", tdqsOn, 1);
    chk("R5 bank3 outOff", outOff, 0);
    chk("R5 bank3 cfgError", cfgError, 0);
    chk("R5 bank3 dllOn", dllOn, 0);
  endtask

  task automatic tSelfRefreshOn();
    doReset();
    srPulse(1'b0);
    chk("R7 stray exit ignored", dllResetPulse, 0);
    srPulse(1'b1);
    chk("R7 dll off on entry", dllOn, 0);
    repeat (3) @(negedge clk);
    chk("R7 dll stays off", dllOn, 0);
    srPulse(1'b0);
    chk("R7 dll back on exit", dllOn, 1);
    chk("R7 reset pulse on exit", dllResetPulse, 1);
    @(negedge clk);
    chk("R7 reset pulse single", dllResetPulse, 0);
  endtask

  task automatic tSelfRefreshOff();
    doReset();
    doWrite(2'b01, 19'd1);
    srPulse(1'b1);
    chk("R8 dll off in sr", dllOn, 0);
    srPulse(1'b0);
    chk("R8 dll stays off after exit", dllOn, 0);
    chk("R8 no reset pulse", dllResetPulse, 0);
  endtask

  task automatic tErrors();
    doReset();
    doWrite(2'b01, 19'd1 << 13);
    chk("R9 reserved bit flags", cfgError, 1);
    doWrite(2'b01, 19'd0);
    chk("R9 flag sticky", cfgError, 1);
    doReset();
    chk("R9 flag cleared by reset", cfgError, 0);
    doWrite(2'b01, 19'd24);
    chk("R9 al 11 flags", cfgError, 1);
    chk("R9 al 11 gives zero", addLat, 0);
    doReset();
    doWrite(2'b01, 19'd32);
    chk("R9 drive 10 flags", cfgError, 1);
    chk("R9 drive stored", driveCode, 2'b10);
    doReset();
    doWrite(2'b01, 19'd1 << 18);
    chk("R9 bit 18 flags", cfgError, 1);
  endtask

  task automatic tTermLegal();
    for (int mode = 0; mode < 3; mode++) begin
      for (int c = 0; c < 8; c++) begin
        logic [18:0] w;
        logic expErr;
        w = termBits(3'(c));
        if (mode >= 1) w = w | (19'd1 << 7);
        if (mode == 2) w = w | (19'd1 << 12);
        if (mode == 0)      expErr = (c > 4);
        else if (mode == 1) expErr = (c > 3);
        else                expErr = (c > 5);
        doReset();
        doWrite(2'b01, w);
        chk($sformatf("R10 mode %0d code %0d", mode, c), cfgError, 32'(expErr));
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tReset();
    tFields();
    tAddLat();
    tDllReset();
    tOtherBanks();
    tSelfRefreshOn();
    tSelfRefreshOff();
    tErrors();
    tTermLegal();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule